// File: doc/BRIEF.md
# Digit Cross-Fade Sequencer

This block sits between whatever produces a multi-digit display word and the serial cathode driver that pushes frames to the tubes. When a new word is requested and it matches the word currently on show, the block hands exactly one frame to the driver and returns to idle. When the word differs, it produces a dissolve. It alternates whole frames of the new and the old word. The new word's share of time grows linearly on every round, and the sequence always finishes with the new word on display, which is then remembered as the word on show.

Time is measured in pulses of a one-millisecond tick input. Frames go to the driver through a load strobe that is only raised while the driver's busy flag is low. The three fade constants are parameters: a starting level, a step and a stop level. Each new-word frame first raises the level by the step and is then held for "level" ticks. Each old-word frame is held for "stop minus level" ticks. The dissolve ends after the first new-word frame whose level has reached or passed the stop level.

Top module: `xfade_seq`

## Requirements
- R1: After reset, `idle` is 1 and `drv_load` is 0.
- R2: A request whose word equals the remembered word produces exactly one load of that word, with no hold time, and the block then returns to idle.
- R3: A request with a different word produces loads that alternate between the new word and the old word, starting with the new word.
- R4: Before each new-word frame the level rises by FADE_STEP, starting from FADE_START. The new-word frame is then held for "level" tick pulses, counted after the load.
- R5: Each old-word frame is held for FADE_STOP minus the current level tick pulses, and the level does not change during it.
- R6: The dissolve ends after the hold of the first new-word frame whose level is at or above FADE_STOP, including exact equality. The last load is the new word, and that word becomes the remembered word.
- R7: `drv_load` is never raised while `drv_busy` is high. A pending frame is loaded in the first cycle in which `drv_busy` is low.
- R8: `req_valid` is sampled only while `idle` is 1. A request made during a dissolve has no effect on the loads or on the remembered word.
- R9: Reset sets the remembered word to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_word | input | WORD_W | Requested display word |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| drv_busy | input | 1 | Driver cannot accept a frame |
| drv_load | output | 1 | Frame load strobe to the driver |
| drv_word | output | WORD_W | Frame contents, valid with drv_load |
| idle | output | 1 | Block can take a request |

## Verification
A request taken at one clock edge gives its first load in the next cycle when the driver is free. Every later load comes in the cycle after the tick that completes the previous hold, and `idle` rises in the cycle after the final tick. The bench samples on the falling edge. It records every load word, and it counts tick pulses in the cycles from each load until the next load or until `idle` returns. It then compares this trace with a list of expected loads and holds that it builds from the fade rule alone. With the driver busy, it checks at each falling edge that no load appears, and it checks that the load comes in the first cycle after the driver is released.

// File: rtl/xfade_pkg.sv
package xfade_pkg;
   typedef enum logic [1:0] {
      XF_IDLE = 2'd0,
      XF_LOAD = 2'd1,
      XF_HOLD = 2'd2
   } xf_state_e;
endpackage

// File: rtl/xfade_hold_timer.sv
module xfade_hold_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] len,
   input  logic          ms_tick,
   output logic          expired
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_q;
   logic          active_q;

   assign expired = active_q && ms_tick && (cnt_q == len_q - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         len_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         len_q    <= len;
      end else if (expired) begin
         active_q <= 1'b0;
      end else if (active_q && ms_tick) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/xfade_level.sv
module xfade_level #(
   parameter int CW         = 8,
   parameter int FADE_START = 20,
   parameter int FADE_STEP  = 20,
   parameter int FADE_STOP  = 200
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          advance,
   output logic [CW-1:0] level,
   output logic [CW-1:0] old_len,
   output logic          finished
);
   localparam logic [CW-1:0] FIRST_C = CW'(FADE_START + FADE_STEP);
   localparam logic [CW-1:0] STEP_C  = CW'(FADE_STEP);
   localparam logic [CW-1:0] STOP_C  = CW'(FADE_STOP);

   logic [CW-1:0] level_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       level_q <= FIRST_C;
      else if (init)    level_q <= FIRST_C;
      else if (advance) level_q <= level_q + STEP_C;
   end

   assign level    = level_q;
   assign finished = (level_q >= STOP_C);
   assign old_len  = finished ? CW'(1) : (STOP_C - level_q);
endmodule

// File: rtl/xfade_seq.sv
module xfade_seq #(
   parameter int WORD_W     = 16,
   parameter int FADE_START = 20,
   parameter int FADE_STEP  = 20,
   parameter int FADE_STOP  = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] req_word,
   input  logic              ms_tick,
   input  logic              drv_busy,
   output logic              drv_load,
   output logic [WORD_W-1:0] drv_word,
   output logic              idle
);
   import xfade_pkg::*;

   localparam int CW = $clog2(FADE_STOP + FADE_STEP + 1);

   generate
      if (FADE_START < 0 || FADE_START >= FADE_STOP) begin : g_bad_start
         $error("xfade_seq: FADE_START must lie in [0, FADE_STOP)");
      end
      if (FADE_STEP <= 0) begin : g_bad_step
         $error("xfade_seq: FADE_STEP must be positive");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("xfade_seq: WORD_W must be positive");
      end
   endgenerate

   xf_state_e         state_q;
   logic [WORD_W-1:0] new_q;
   logic [WORD_W-1:0] prev_q;
   logic              same_q;
   logic              phase_new_q;

   logic              lvl_init;
   logic              lvl_adv;
   logic [CW-1:0]     level;
   logic [CW-1:0]     old_len;
   logic              finished;
   logic              tmr_start;
   logic [CW-1:0]     tmr_len;
   logic              expired;
   logic              accept;

   assign idle      = (state_q == XF_IDLE);
   assign accept    = idle && req_valid;
   assign drv_load  = (state_q == XF_LOAD) && !drv_busy;
   assign drv_word  = phase_new_q ? new_q : prev_q;
   assign lvl_init  = accept;
   assign lvl_adv   = (state_q == XF_HOLD) && expired && !phase_new_q;
   assign tmr_start = drv_load && !same_q;
   assign tmr_len   = phase_new_q ? level : old_len;

   xfade_level #(
      .CW(CW), .FADE_START(FADE_START), .FADE_STEP(FADE_STEP), .FADE_STOP(FADE_STOP)
   ) u_level (
      .clk(clk), .rst_n(rst_n), .init(lvl_init), .advance(lvl_adv),
      .level(level), .old_len(old_len), .finished(finished)
   );

   xfade_hold_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len),
      .ms_tick(ms_tick), .expired(expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= XF_IDLE;
         new_q       <= '0;
         prev_q      <= '0;
         same_q      <= 1'b0;
         phase_new_q <= 1'b1;
      end else begin
         unique case (state_q)
            XF_IDLE: begin
               if (req_valid) begin
                  new_q       <= req_word;
                  same_q      <= (req_word == prev_q);
                  phase_new_q <= 1'b1;
                  state_q     <= XF_LOAD;
               end
            end
            XF_LOAD: begin
               if (!drv_busy) state_q <= same_q ? XF_IDLE : XF_HOLD;
            end
            XF_HOLD: begin
               if (expired) begin
                  if (phase_new_q) begin
                     if (finished) begin
                        prev_q  <= new_q;
                        state_q <= XF_IDLE;
                     end else begin
                        phase_new_q <= 1'b0;
                        state_q     <= XF_LOAD;
                     end
                  end else begin
                     phase_new_q <= 1'b1;
                     state_q     <= XF_LOAD;
                  end
               end
            end
            default: state_q <= XF_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xfade_seq_chk.sv
module xfade_seq_chk #(
   parameter int WORD_W = 16,
   parameter int CW     = 8,
   parameter int LIMIT  = 220
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle,
   input logic              drv_load,
   input logic              drv_busy,
   input logic [WORD_W-1:0] new_q,
   input logic [WORD_W-1:0] prev_q,
   input logic [CW-1:0]     level
);
   // R7
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_load |-> !drv_busy);
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !drv_load);
   // R3
   single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_load |=> !drv_load);
   // R6
   settle_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> (new_q == prev_q));
   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(level) < LIMIT);
endmodule

bind xfade_seq xfade_seq_chk #(
   .WORD_W(WORD_W), .CW(CW), .LIMIT(FADE_STOP + FADE_STEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .idle(idle), .drv_load(drv_load),
   .drv_busy(drv_busy), .new_q(new_q), .prev_q(prev_q), .level(level)
);

// File: tb/xfade_seq_tb.sv
`timescale 1ns/1ps
module xfade_seq_tb;
   localparam int W     = 16;
   localparam int START = 1;
   localparam int STEP  = 3;
   localparam int STOP  = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [W-1:0] req_word = '0;
   logic         ms_tick = 1'b0;
   logic         drv_busy = 1'b0;
   logic         drv_load;
   logic [W-1:0] drv_word;
   logic         idle;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   xfade_seq #(.WORD_W(W), .FADE_START(START), .FADE_STEP(STEP), .FADE_STOP(STOP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
      .ms_tick(ms_tick), .drv_busy(drv_busy), .drv_load(drv_load),
      .drv_word(drv_word), .idle(idle)
   );

   // millisecond tick: one pulse every fourth cycle
   initial begin
      forever begin
         repeat (3) @(posedge clk);
         #1 ms_tick = 1'b1;
         @(posedge clk);
         #1 ms_tick = 1'b0;
      end
   end

   // trace recorder
   logic [W-1:0] lw [16];
   int           lt [16];
   int           nl = 0;
   bit           rec = 0;
   always @(negedge clk) begin
      if (rec) begin
         if (drv_load) begin
            if (nl < 16) begin
               lw[nl] = drv_word;
               lt[nl] = 0;
            end
            nl++;
         end else if (nl > 0 && nl <= 16 && !idle && ms_tick) begin
            lt[nl-1]++;
         end
      end
   end

   // expected trace
   logic [W-1:0] ew [16];
   int           et [16];
   bit           enew [16];
   int           ecnt;

   task automatic build_model(input logic [W-1:0] oldw, input logic [W-1:0] neww);
      int lvl;
      ecnt = 0;
      if (oldw == neww) begin
         ew[0] = neww; et[0] = 0; enew[0] = 1; ecnt = 1;
      end else begin
         lvl = START;
         while (1) begin
            lvl += STEP;
            ew[ecnt] = neww; et[ecnt] = lvl; enew[ecnt] = 1; ecnt++;
            if (lvl >= STOP) break;
            ew[ecnt] = oldw; et[ecnt] = STOP - lvl; enew[ecnt] = 0; ecnt++;
         end
      end
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [W-1:0] w);
      @(posedge clk);
      #1 req_valid = 1'b1; req_word = w;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!idle) @(negedge clk);
   endtask

   task automatic compare(input string tag);
      check(nl == ecnt, {tag, " R3 load count"}, nl, ecnt);
      for (int i = 0; i < ecnt && i < nl; i++) begin
         check(lw[i] == ew[i], {tag, ecnt == 1 ? " R2 word" : " R3 word"}, lw[i], ew[i]);
         check(lt[i] == et[i], {tag, ecnt == 1 ? " R2 hold" : (enew[i] ? " R4 new hold" : " R5 old hold")},
               lt[i], et[i]);
      end
      if (nl > 0 && nl == ecnt)
         check(lw[nl-1] == ew[ecnt-1], {tag, " R6 final word"}, lw[nl-1], ew[ecnt-1]);
   endtask

   task automatic run_req(input logic [W-1:0] oldw, input logic [W-1:0] neww, input string tag);
      build_model(oldw, neww);
      nl = 0; rec = 1;
      send(neww);
      wait_idle();
      repeat (3) @(negedge clk);
      rec = 0;
      compare(tag);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(idle == 1'b1, "R1 idle after reset", idle, 1);
      check(drv_load == 1'b0, "R1 no load after reset", drv_load, 0);
   endtask

   task automatic t_prev_zero();
      // R9: remembered word is zero after reset, so zero gives a single load (R2)
      run_req(16'h0000, 16'h0000, "R9 zero after reset");
   endtask

   task automatic t_fade_a();
      // R3 R4 R5 R6: level lands exactly on STOP (4,7,10)
      run_req(16'h0000, 16'h1234, "fadeA");
      run_req(16'h1234, 16'h1234, "R6 remembered");
   endtask

   task automatic t_fade_b();
      run_req(16'h1234, 16'hABCD, "fadeB");
   endtask

   task automatic t_busy();
      bit saw_load;
      build_model(16'hABCD, 16'h0F0F);
      nl = 0; rec = 1;
      #1 drv_busy = 1'b1;
      send(16'h0F0F);
      saw_load = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (drv_load) saw_load = 1;
      end
      check(!saw_load, "R7 no load while busy", saw_load, 0);
      @(posedge clk);
      #1 drv_busy = 1'b0;
      @(negedge clk);
      check(drv_load == 1'b1, "R7 load when busy drops", drv_load, 1);
      check(drv_word == 16'h0F0F, "R7 load word", drv_word, 16'h0F0F);
      wait_idle();
      repeat (3) @(negedge clk);
      rec = 0;
      compare("busy");
   endtask

   task automatic t_ignore();
      build_model(16'h0F0F, 16'h7777);
      nl = 0; rec = 1;
      send(16'h7777);
      repeat (30) @(posedge clk);
      #1 check(idle == 1'b0, "R8 busy mid-fade", idle, 0);
      req_valid = 1'b1; req_word = 16'h5555;
      @(posedge clk);
      #1 req_valid = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);
      rec = 0;
      compare("R8 ignored req");
      run_req(16'h7777, 16'h7777, "R8 prev kept");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_prev_zero();
      t_fade_a();
      t_fade_b();
      t_busy();
      t_ignore();
      repeat (4) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule